// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the data-output side of a serial 10-bit analog-to-digital converter, so that an SPI master can be tested in loopback without the analog part. A 10-bit sample arrives on a parallel input. The master drives an active-low chip select and a serial clock. The block runs on its own system clock. It oversamples both SPI lines through synchronizers and drives a serial data line together with an explicit output-enable. Output-enable low stands for the high-impedance state, so no bidirectional pin is needed.

Each frame follows a fixed sequence. The block captures the sample when chip select goes low. The output then stays disabled for the first two serial clocks. After that it drives a zero null bit, the word from the top bit down, and a mirrored replay from bit 1 back up to the top bit. Then it disables the output again. The output updates only on falling serial clock edges. The position in the frame is counted in rising edges, so the same sequence reaches a master that samples on rising edges whether the clock idles low or idles high. Raising chip select ends the frame at any point.

Top module: `adc_serial_emu`

## Requirements
- R1: `sdo_oe` is 0 during reset and whenever `spi_csn` is high. It falls no later than 3 `clk` cycles after `spi_csn` rises.
- R2: While `spi_csn` is low, `sdo` and `sdo_oe` change only in response to a falling edge of `spi_sclk`. The update appears 3 `clk` cycles after that edge, and the outputs hold steady through the high phase of `spi_sclk`.
- R3: Counting rising edges of `spi_sclk` from 1 within a frame, the value seen at rising edges 1 and 2 is `sdo_oe` = 0.
- R4: At rising edge 3, `sdo_oe` = 1 and `sdo` = 0 (the null bit).
- R5: At rising edges 4 through 13, `sdo` carries sample bits 9 down to 0 in that order (bit 9 is the MSB), with `sdo_oe` = 1.
- R6: At rising edges 14 through 22, `sdo` carries sample bits 1 up to 9 in that order, with `sdo_oe` = 1.
- R7: From rising edge 23 on, `sdo_oe` = 0 however many clocks follow.
- R8: The sequence of R3 to R7 is the same when `spi_sclk` idles low and when it idles high.
- R9: `sample_in` is captured when `spi_csn` falls. Changes to `sample_in` during the frame do not affect the bits driven in that frame.
- R10: Raising `spi_csn` in the middle of a frame aborts it. The next frame starts again from the lead-in of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Active-low chip select from the SPI master |
| spi_sclk | input | 1 | Serial clock from the SPI master, either idle level |
| sample_in | input | DATA_W | Parallel sample to be sent |
| sdo | output | 1 | Serial data out, meaningful only when `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable; 0 models high impedance |

## Verification
The assertions check four rules on every cycle. The output must be disabled while chip select is high. The outputs must hold between falling edges. The null bit must follow the second rising edge, and the output must be disabled once the replay is finished. The captured word must hold for the whole frame. The bench scenarios are the only evidence for the order of the data bits in the MSB-first word and in the LSB-first replay, for matching behaviour under both clock idle levels, for a sample that changes mid-frame being ignored, and for an aborted frame restarting cleanly.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Value a frame slot puts on the pin: drive=0 means high impedance.
  typedef struct packed {
    logic drive;
    logic bit_val;
  } out_slot_t;

  localparam out_slot_t SLOT_HIZ = '{drive: 1'b0, bit_val: 1'b0};

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int CNT_MAX = 22,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear)                 count_q <= '0;
    else if (step && count_q != LIMIT) count_q <= count_q + 1'b1;
  end

  assign count = count_q;

  // R7
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == LIMIT && !clear) |=> (count_q == LIMIT));

endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LEAD   = 2,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] word,
  output out_slot_t         slot
);

  localparam logic [CNT_W-1:0] NULL_AT  = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] LSB_AT   = CNT_W'(LEAD + DATA_W);
  localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(LEAD + 2 * DATA_W - 1);

  logic [CNT_W-1:0] idx;
  logic             in_word;
  logic             sel_bit;

  always_comb begin
    idx     = '0;
    in_word = 1'b0;
    if (count > NULL_AT && count <= LSB_AT) begin
      idx     = LSB_AT - count;       // descending half
      in_word = 1'b1;
    end else if (count > LSB_AT && count <= LAST_AT) begin
      idx     = count - LSB_AT;       // ascending replay
      in_word = 1'b1;
    end
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (idx == CNT_W'(i)) sel_bit = word[i];
    end
  end

  always_comb begin
    slot = SLOT_HIZ;
    if (count == NULL_AT) begin
      slot.drive   = 1'b1;
      slot.bit_val = 1'b0;
    end else if (in_word) begin
      slot.drive   = 1'b1;
      slot.bit_val = sel_bit;
    end
  end

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int LEAD_CLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_MAX = LEAD_CLKS + 2 * DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              csn_lvl, csn_rise, csn_fall;
  logic              sck_lvl, sck_rise, sck_fall;
  logic              cs_active, cs_start;
  logic [CNT_W-1:0]  edge_cnt;
  logic [DATA_W-1:0] word_q;
  out_slot_t         slot;
  logic              sdo_q, oe_q;

  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(spi_csn),
    .level(csn_lvl), .rise(csn_rise), .fall(csn_fall)
  );

  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst(rst), .din(spi_sclk),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
  );

  assign cs_active = ~csn_lvl;
  assign cs_start  = csn_fall;

  // Capture the sample once per frame.
  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (cs_start) word_q <= sample_in;
  end

  frame_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clear(~cs_active),
    .step(cs_active & sck_rise),
    .count(edge_cnt)
  );

  bit_sequencer #(.DATA_W(DATA_W), .LEAD(LEAD_CLKS), .CNT_W(CNT_W)) u_seq (
    .count(edge_cnt), .word(word_q), .slot(slot)
  );

  // Registered pin drivers, updated on falling serial edges only.
  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else if (sck_fall) begin
      oe_q  <= slot.drive;
      sdo_q <= slot.bit_val & slot.drive;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  // R1
  cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !sdo_oe);

  // R2
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && !sck_fall) |=> ($stable(sdo) && $stable(sdo_oe)));

  // R4
  null_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && sck_fall && edge_cnt == CNT_W'(LEAD_CLKS)) |=> (sdo_oe && !sdo));

  // R7
  tail_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && sck_fall && edge_cnt == CNT_W'(CNT_MAX)) |=> !sdo_oe);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_active && !cs_start) |=> $stable(word_q));

  // Unused edge output kept visible for completeness of the sync instance.
  logic unused_ok;
  assign unused_ok = &{1'b0, csn_rise, sck_lvl};

endmodule

// File: tb/tb_adc_serial_emu.sv
module tb_adc_serial_emu;

  localparam int DATA_W = 10;
  localparam int HALF   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              spi_csn = 1'b1;
  logic              spi_sclk = 1'b0;
  logic [DATA_W-1:0] sample_in = '0;
  logic              sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_emu #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected {drive, value} after n rising edges in the frame.
  function automatic logic [1:0] exp_slot(int n, logic [DATA_W-1:0] w);
    if (n < 2)       return 2'b00;
    if (n == 2)      return 2'b10;
    if (n <= 12)     return {1'b1, w[12 - n]};
    if (n <= 21)     return {1'b1, w[n - 12]};
    return 2'b00;
  endfunction

  function automatic string tag_of(int n);
    if (n < 2)   return "R3";
    if (n == 2)  return "R4";
    if (n <= 12) return "R5";
    if (n <= 21) return "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [1:0] exp);
    logic [1:0] act;
    act = {sdo_oe, sdo};
    checks++;
    if (act[1] !== exp[1] || (exp[1] && act[0] !== exp[0])) begin
      errors++;
      $display("FAIL %s: {oe,sdo} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One frame: idle_hi selects the clock idle level (R8),
  // nclk rising edges, optional mid-frame sample change (R9).
  task automatic run_frame(bit idle_hi, logic [DATA_W-1:0] w, int nclk,
                           bit scramble, string extra);
    spi_sclk  = idle_hi;
    sample_in = w;
    wait_clks(HALF);
    spi_csn = 1'b0;
    wait_clks(HALF);
    for (int k = 1; k <= nclk; k++) begin
      if (scramble && k == 3) sample_in = DATA_W'($urandom);
      if (idle_hi) begin
        spi_sclk = 1'b0;
        wait_clks(HALF);
      end
      chk({tag_of(k - 1), extra, idle_hi ? " R8" : ""}, exp_slot(k - 1, w));
      spi_sclk = 1'b1;
      wait_clks(HALF - 1);
      chk({"R2 ", tag_of(k - 1)}, exp_slot(k - 1, w));
      wait_clks(1);
      if (!idle_hi) begin
        spi_sclk = 1'b0;
        wait_clks(HALF);
      end
    end
    spi_csn = 1'b1;
    wait_clks(4);
    chk({"R1", extra}, 2'b00);
    sample_in = DATA_W'($urandom);
    wait_clks(HALF);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    wait_clks(5);
    chk("R1 reset", 2'b00);
    rst = 1'b0;
    wait_clks(5);
    chk("R1 idle", 2'b00);

    // Directed corners
    run_frame(1'b0, 10'b10_0000_0001, 22, 1'b0, "");
    run_frame(1'b1, 10'b01_1111_1110, 22, 1'b0, "");
    run_frame(1'b0, 10'h3FF, 28, 1'b0, "");       // R7 extra clocks
    run_frame(1'b1, 10'h000, 28, 1'b0, "");
    run_frame(1'b0, 10'h2A5, 16, 1'b0, " R9");    // 16-clock frame
    run_frame(1'b0, 10'h15A, 22, 1'b1, " R9");    // sample changes mid-frame
    run_frame(1'b1, 10'h0F3, 22, 1'b1, " R9");
    // R10: abort mid-frame then a clean frame
    run_frame(1'b0, 10'h3C3, 7, 1'b0, " R10");
    run_frame(1'b0, 10'h1E7, 22, 1'b0, " R10");
    run_frame(1'b1, 10'h2DB, 5, 1'b0, " R10");
    run_frame(1'b1, 10'h064, 22, 1'b0, " R10");

    // Random frames
    for (int f = 0; f < 24; f++) begin
      bit hi;
      int n;
      hi = 1'($urandom);
      n  = 2 + int'($urandom % 27);
      run_frame(hi, DATA_W'($urandom), n, 1'($urandom), "");
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule